// File: doc/BRIEF.md
# Stream Table Entry Address Walker

This block turns a stream identifier into the byte address of that stream's 64-byte table entry. In flat format the entry address is computed directly from the table base. In two-level format the identifier is split into a high part, which selects an 8-byte first-level descriptor, and a low part, which indexes a second-level array of entries. The walker reads that descriptor over a memory read port, checks it, and builds the entry address from the pointer it holds. It does not fetch or decode the entry itself.

Requests arrive on a valid/ready port, and the walker holds one request at a time. `req_ready` is high only while the walker is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The memory request port is valid/ready. Once `mem_req_valid` is raised it stays high, with `mem_req_addr` unchanged, until `mem_req_ready` is seen. The memory response port is valid/ready, and `mem_rsp_ready` is high only while the descriptor read is outstanding. The result is a single-cycle pulse with no back-pressure. The configuration inputs must stay stable from the acceptance of a request until its result.

Descriptor layout: bit 0 is the valid flag. Bits 5:1 hold the span, a log2 count of the level-2 entries. Bits 63:6 hold the 64-byte-aligned level-2 pointer. Fault codes on `res_fault`: 0 none, 1 stream id out of range, 2 illegal split, 3 invalid descriptor, 4 beyond descriptor span.

Top module: `stw_walker`

## Requirements
- R1: `req_ready` is high only when no request is in flight. While the memory request or response handshake is pending, `req_ready` is low.
- R2: A stream id with `sid >= 2**cfg_log2size` returns fault 1, and no memory read is issued. This check takes priority over every other fault.
- R3: In flat format (`cfg_two_level`=0) the result is `cfg_base + sid*64` with fault 0. It pulses on the second rising edge after acceptance, and no memory read is issued.
- R4: In two-level format a `cfg_split` other than 7, 8 or 16 returns fault 2 with no memory read. In flat format the split value has no effect.
- R5: In two-level format one descriptor read is issued at `cfg_base + (sid >> split)*8`. The address stays stable while `mem_req_ready` is low.
- R6: A returned descriptor with bit 0 clear returns fault 3. This is checked before the span.
- R7: With span `s` in descriptor bits 5:1 and `low = sid mod 2**split`, a value `low >= 2**s` returns fault 4.
- R8: For a valid descriptor in range, the result is `{desc[63:6],6'b0} + low*64` with fault 0. It pulses on the edge after the response handshake.
- R9: `res_valid` is high for exactly one cycle per request. When the fault is nonzero, `res_addr` is 0.
- R10: After reset, `req_ready`=1, `res_valid`=0 and `mem_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Table base byte address |
| cfg_two_level | input | 1 | 1 selects two-level format |
| cfg_split | input | 5 | Number of low sid bits indexing level 2 |
| cfg_log2size | input | 6 | log2 of the number of stream ids |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_sid | input | SIDW | Stream id |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | AW | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_ready | output | 1 | Walker awaits descriptor data |
| mem_rsp_data | input | 64 | Descriptor doubleword |
| res_valid | output | 1 | One-cycle result pulse |
| res_addr | output | AW | Entry address, 0 on fault |
| res_fault | output | 3 | Fault code, 0 when none |

## Verification
The hardest cases to reach are the ones where two faults apply at once and only one may be reported. Examples are an out-of-range id under an illegal split, or a descriptor that is both invalid and too narrow. Directed tasks build exactly those combinations to check the priority. Memory back-pressure is forced by holding `mem_req_ready` low for several cycles while the bench watches that the request stays put. The span check is driven at both sides of its boundary, and at span 0 with low index 0, to catch off-by-one comparisons.

// File: rtl/stw_pkg.sv
package stw_pkg;
  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_SID_RANGE = 3'd1,
    FLT_BAD_SPLIT = 3'd2,
    FLT_L1_INVAL  = 3'd3,
    FLT_L1_SPAN   = 3'd4
  } stw_fault_e;

  localparam int DESC_W     = 64;
  localparam int L1_SHIFT   = 3;  // 8-byte level-1 descriptors
  localparam int ENT_SHIFT  = 6;  // 64-byte table entries
endpackage

// File: rtl/stw_precheck.sv
module stw_precheck
  import stw_pkg::*;
#(
  parameter int SIDW   = 20,
  parameter int AW     = 64,
  parameter int SPLITW = 5,
  parameter int LOGW   = 6
) (
  input  logic [SIDW-1:0]   sid,
  input  logic [AW-1:0]     base,
  input  logic              two_level,
  input  logic [SPLITW-1:0] split,
  input  logic [LOGW-1:0]   log2size,
  output stw_fault_e        fault,
  output logic [AW-1:0]     flat_addr,
  output logic [AW-1:0]     l1_addr,
  output logic [SIDW-1:0]   low_idx
);
  localparam int NLEGAL = 3;
  localparam logic [SPLITW-1:0] LEGAL [NLEGAL] = '{SPLITW'(7), SPLITW'(8), SPLITW'(16)};

  logic [NLEGAL-1:0] hit;
  logic [SIDW-1:0]   hi_idx;
  logic              range_bad;

  for (genvar g = 0; g < NLEGAL; g++) begin : g_legal
    assign hit[g] = (split == LEGAL[g]);
  end

  assign range_bad = ((sid >> log2size) != '0);
  assign hi_idx    = sid >> split;
  assign low_idx   = sid & ~({SIDW{1'b1}} << split);
  assign flat_addr = base + (AW'(sid) << ENT_SHIFT);
  assign l1_addr   = base + (AW'(hi_idx) << L1_SHIFT);

  always_comb begin
    if (range_bad)                  fault = FLT_SID_RANGE;
    else if (two_level && hit == '0) fault = FLT_BAD_SPLIT;
    else                            fault = FLT_NONE;
  end
endmodule

// File: rtl/stw_l1_decode.sv
module stw_l1_decode
  import stw_pkg::*;
#(
  parameter int SIDW = 20,
  parameter int AW   = 64
) (
  input  logic [DESC_W-1:0] desc,
  input  logic [SIDW-1:0]   low_idx,
  output stw_fault_e        fault,
  output logic [AW-1:0]     ent_addr
);
  logic       vld;
  logic [4:0] span;
  logic [AW-1:0] l2_ptr;

  assign vld      = desc[0];
  assign span     = desc[5:1];
  assign l2_ptr   = {desc[AW-1:ENT_SHIFT], {ENT_SHIFT{1'b0}}};
  assign ent_addr = l2_ptr + (AW'(low_idx) << ENT_SHIFT);

  always_comb begin
    if (!vld)                        fault = FLT_L1_INVAL;
    else if ((low_idx >> span) != '0) fault = FLT_L1_SPAN;
    else                             fault = FLT_NONE;
  end
endmodule

// File: rtl/stw_walker.sv
module stw_walker
  import stw_pkg::*;
#(
  parameter int SIDW = 20,
  parameter int AW   = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cfg_base,
  input  logic            cfg_two_level,
  input  logic [4:0]      cfg_split,
  input  logic [5:0]      cfg_log2size,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [SIDW-1:0] req_sid,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_req_addr,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic [63:0]     mem_rsp_data,
  output logic            res_valid,
  output logic [AW-1:0]   res_addr,
  output logic [2:0]      res_fault
);
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_ISSUE, S_WAIT} st_e;

  st_e             state;
  logic [SIDW-1:0] sid_q;
  logic [AW-1:0]   l1_q;
  logic            rv_q;
  logic [AW-1:0]   ra_q;
  stw_fault_e      rf_q;

  stw_fault_e      pre_fault, dec_fault;
  logic [AW-1:0]   flat_addr, l1_addr, ent_addr;
  logic [SIDW-1:0] low_idx;

  stw_precheck #(.SIDW(SIDW), .AW(AW), .SPLITW(5), .LOGW(6)) u_pre (
    .sid(sid_q), .base(cfg_base), .two_level(cfg_two_level),
    .split(cfg_split), .log2size(cfg_log2size),
    .fault(pre_fault), .flat_addr(flat_addr), .l1_addr(l1_addr),
    .low_idx(low_idx)
  );

  stw_l1_decode #(.SIDW(SIDW), .AW(AW)) u_dec (
    .desc(mem_rsp_data), .low_idx(low_idx),
    .fault(dec_fault), .ent_addr(ent_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sid_q <= '0;
      l1_q  <= '0;
      rv_q  <= 1'b0;
      ra_q  <= '0;
      rf_q  <= FLT_NONE;
    end else begin
      rv_q <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          sid_q <= req_sid;
          state <= S_CHECK;
        end
        S_CHECK: begin
          if (pre_fault != FLT_NONE) begin
            rv_q  <= 1'b1;
            rf_q  <= pre_fault;
            ra_q  <= '0;
            state <= S_IDLE;
          end else if (!cfg_two_level) begin
            rv_q  <= 1'b1;
            rf_q  <= FLT_NONE;
            ra_q  <= flat_addr;
            state <= S_IDLE;
          end else begin
            l1_q  <= l1_addr;
            state <= S_ISSUE;
          end
        end
        S_ISSUE: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          rv_q  <= 1'b1;
          rf_q  <= dec_fault;
          ra_q  <= (dec_fault == FLT_NONE) ? ent_addr : '0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_ISSUE);
  assign mem_req_addr  = l1_q;
  assign mem_rsp_ready = (state == S_WAIT);
  assign res_valid     = rv_q;
  assign res_addr      = ra_q;
  assign res_fault     = rf_q;
endmodule

// File: rtl/stw_walker_chk.sv
module stw_walker_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_two_level,
  input logic          req_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_valid,
  input logic          mem_rsp_ready,
  input logic          res_valid,
  input logic [AW-1:0] res_addr,
  input logic [2:0]    res_fault
);
  assert_busy_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || mem_rsp_ready) |-> !req_ready);

  assert_flat_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> cfg_two_level);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_rsp_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_ready) |=> res_valid);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_fault_zero_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault != 3'd0) |-> (res_addr == '0));

  assert_phase_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));
endmodule

bind stw_walker stw_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_two_level(cfg_two_level),
  .req_ready(req_ready), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
  .res_valid(res_valid), .res_addr(res_addr), .res_fault(res_fault)
);

// File: tb/tb_stw_walker.sv
`timescale 1ns/100ps
module tb_stw_walker;
  localparam int SIDW = 20;
  localparam int AW   = 64;
  localparam logic [AW-1:0] BASE = 64'h1000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] cfg_base = BASE;
  logic cfg_two_level = 1'b0;
  logic [4:0] cfg_split = 5'd8;
  logic [5:0] cfg_log2size = 6'd10;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [SIDW-1:0] req_sid = '0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic res_valid;
  logic [AW-1:0] res_addr;
  logic [2:0] res_fault;

  int checks = 0;
  int errors = 0;
  int mem_hs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stw_walker #(.SIDW(SIDW), .AW(AW)) dut (.*);

  always @(posedge clk) if (mem_req_valid && mem_req_ready) mem_hs++;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_req(logic [SIDW-1:0] sid);
    @(negedge clk);
    req_valid = 1'b1;
    req_sid = sid;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wait_res(output logic [AW-1:0] a, output logic [2:0] f, output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!res_valid && cyc < 100);
    a = res_addr;
    f = res_fault;
    @(negedge clk);
    chk("R9 pulse width", {63'd0, res_valid}, 64'd0);
  endtask

  // request resolved without memory: flat result or early fault
  task automatic run_direct(string tag, logic [SIDW-1:0] sid,
                            logic [2:0] exp_f, logic [AW-1:0] exp_a);
    int hs0, cyc;
    logic [AW-1:0] a;
    logic [2:0] f;
    hs0 = mem_hs;
    send_req(sid);
    wait_res(a, f, cyc);
    chk({tag, " fault"}, 64'(f), 64'(exp_f));
    chk({tag, " addr"}, a, exp_a);
    chk({tag, " latency"}, 64'(cyc), 64'd2);
    chk({tag, " no read"}, 64'(mem_hs - hs0), 64'd0);
  endtask

  // two-level request with descriptor read and optional back-pressure
  task automatic run_walk(string tag, logic [SIDW-1:0] sid, logic [AW-1:0] exp_l1,
                          int stall, logic [63:0] desc,
                          logic [2:0] exp_f, logic [AW-1:0] exp_a);
    int n, cyc;
    logic [AW-1:0] a;
    logic [2:0] f;
    send_req(sid);
    n = 0;
    do begin @(negedge clk); n++; end while (!mem_req_valid && n < 100);
    chk({tag, " R5 l1 addr"}, mem_req_addr, exp_l1);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk({tag, " R5 hold"}, {63'd0, mem_req_valid}, 64'd1);
      chk({tag, " R5 stable"}, mem_req_addr, exp_l1);
    end
    mem_req_ready = 1'b1;
    @(posedge clk);
    #1 mem_req_ready = 1'b0;
    @(negedge clk);
    chk({tag, " R1 busy"}, {63'd0, req_ready}, 64'd0);
    mem_rsp_valid = 1'b1;
    mem_rsp_data = desc;
    @(posedge clk);
    #1 mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    wait_res(a, f, cyc);
    chk({tag, " fault"}, 64'(f), 64'(exp_f));
    chk({tag, " addr"}, a, exp_a);
    chk({tag, " R8 latency"}, 64'(cyc), 64'd1);
  endtask

  task automatic t_reset;
    chk("R10 req_ready", {63'd0, req_ready}, 64'd1);
    chk("R10 res_valid", {63'd0, res_valid}, 64'd0);
    chk("R10 mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
  endtask

  task automatic t_flat;
    cfg_two_level = 1'b0; cfg_log2size = 6'd10; cfg_split = 5'd8;
    run_direct("R3 flat sid5", 20'd5, 3'd0, BASE + 64'h140);
    run_direct("R3 flat top sid", 20'd1023, 3'd0, BASE + 64'hFFC0);
    cfg_split = 5'd9;
    run_direct("R4 flat ignores split", 20'd3, 3'd0, BASE + 64'hC0);
  endtask

  task automatic t_range;
    cfg_two_level = 1'b0; cfg_log2size = 6'd10; cfg_split = 5'd8;
    run_direct("R2 flat sid1024", 20'd1024, 3'd1, '0);
    cfg_two_level = 1'b1; cfg_split = 5'd9;
    run_direct("R2 priority over split", 20'd2000, 3'd1, '0);
  endtask

  task automatic t_bad_split;
    cfg_two_level = 1'b1; cfg_log2size = 6'd20;
    cfg_split = 5'd9;
    run_direct("R4 split9", 20'd3, 3'd2, '0);
    cfg_split = 5'd0;
    run_direct("R4 split0", 20'd3, 3'd2, '0);
  endtask

  task automatic t_walk_ok;
    cfg_two_level = 1'b1; cfg_log2size = 6'd20;
    cfg_split = 5'd8;
    run_walk("R8 split8", 20'h345, BASE + 64'h18, 3, 64'h2000_0011, 3'd0, 64'h2000_1140);
    cfg_split = 5'd7;
    run_walk("R8 split7", 20'h345, BASE + 64'h30, 0, 64'h3000_000F, 3'd0, 64'h3000_1140);
    cfg_split = 5'd16;
    run_walk("R8 split16", 20'h12345, BASE + 64'h8, 2, 64'h4000_0021, 3'd0, 64'h4008_D140);
  endtask

  task automatic t_desc_faults;
    cfg_two_level = 1'b1; cfg_log2size = 6'd20; cfg_split = 5'd8;
    run_walk("R6 invalid", 20'h345, BASE + 64'h18, 1, 64'h2000_0010, 3'd3, '0);
    run_walk("R6 invalid before span", 20'h345, BASE + 64'h18, 0, 64'h2000_0000, 3'd3, '0);
    run_walk("R7 span6 low69", 20'h345, BASE + 64'h18, 0, 64'h2000_000D, 3'd4, '0);
    run_walk("R7 span7 low69", 20'h345, BASE + 64'h18, 0, 64'h2000_000F, 3'd0, 64'h2000_1140);
    run_walk("R7 span0 low0", 20'h300, BASE + 64'h18, 0, 64'h2000_0001, 3'd0, 64'h2000_0000);
    run_walk("R7 span0 low1", 20'h301, BASE + 64'h18, 0, 64'h2000_0001, 3'd4, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_flat;
    t_range;
    t_bad_split;
    t_walk_ok;
    t_desc_faults;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule